// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address. It walks a tree of page tables that are held in memory. Each table is one 4 KB page of 512 entries, and each entry is 8 bytes. The walk starts at a root table whose page number sits in a register inside the block. Software loads that register through a dedicated port, and the block accepts the load only while no walk is in progress.

A translation request enters through a valid/ready handshake, and the block takes one request at a time. The walker then reads one 64-bit entry per level from a simple memory port. It holds each read until the response comes back. Each entry is decoded as one of three things: an invalid entry, a pointer to the next table, or a leaf that names the final physical page.

The block finishes with a single-cycle response. The response carries either the physical address or a fault flag. The 12-bit page offset passes through untouched.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, mem_req_valid is 0 and rsp_valid is 0. The root page number resets to 0.
- R2: req_ready is high only while the walker is idle. A request taken with req_valid and req_ready both high drops req_ready on the next cycle and keeps it low until the response has been given.
- R3: The first read of a walk goes to address (root_ppn << 12) + va[38:30] * 8.
- R4: Each later read goes to address (pointer PPN << 12) + index * 8. The pointer PPN is bits 53:10 of the previous entry. The index is va[29:21] for the second read and va[20:12] for the third.
- R5: Once mem_req_valid rises, it stays high and mem_req_addr stays unchanged until a cycle with mem_resp_valid high.
- R6: An entry with bit 0 clear ends the walk. The response then has rsp_fault = 1 and rsp_pa = 0, and no further reads are issued.
- R7: A valid entry with any of bits 3:1 set is a leaf, at whatever level it is found. The response then has rsp_fault = 0 and rsp_pa = {entry[53:10], va[11:0]}. Bits 63:54 and 9:4 of the entry are ignored.
- R8: A valid entry with bits 3:1 all clear, fetched by the third read, ends the walk with a fault.
- R9: rsp_valid is a one-cycle pulse, and req_ready is high again in the following cycle.
- R10: A root load (root_we) is taken only while the walker is idle. A load offered during a walk has no effect on that walk or on later ones.
- R11: A walk issues at most three reads. The read count is 1, 2 or 3 according to the level at which the walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| root_we | input | 1 | Load strobe for the root page number |
| root_ppn | input | 44 | Physical page number of the top-level table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 39 | Virtual address to translate |
| mem_req_valid | output | 1 | Entry read outstanding |
| mem_req_addr | output | 56 | Byte address of the entry being read |
| mem_resp_valid | input | 1 | Read data returned this cycle |
| mem_resp_data | input | 64 | Page table entry read from memory |
| rsp_valid | output | 1 | Translation result pulse |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_pa | output | 56 | Translated physical address, zero on a fault |

## Verification
Some properties are checked by assertions on every cycle. These cover the memory read staying steady until its data arrives, the handshake and the response pulse, root-register stability during a walk, and a zero address on every fault. Other behaviour can only be shown by the bench's scenarios. That covers the address arithmetic at each level, the decoding of entries (pointer, leaf at different levels, invalid, pointer at the bottom), the pass-through of the offset and the read count per walk. It also covers the fact that a root load during a walk is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_L2,
      WS_L1,
      WS_L0,
      WS_DONE,
      WS_FAULT
   } walk_state_e;

   typedef enum logic [1:0] {
      PK_INVALID,
      PK_POINTER,
      PK_LEAF
   } pte_kind_e;

endpackage

// File: rtl/ptw_addr.sv
// Forms the byte address of the entry to fetch at the current level.
module ptw_addr #(
   parameter int PA_W        = 56,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int LEVELS      = 3,
   parameter int ENTRY_BYTES = 8,
   parameter bit USE_CONCAT  = 1'b1,
   localparam int PPN_W      = PA_W - OFF_W,
   localparam int VPN_W      = LEVELS * IDX_W,
   localparam int LVL_W      = $clog2(LEVELS),
   localparam int SH         = $clog2(ENTRY_BYTES)
) (
   input  logic [VPN_W-1:0] vpn,
   input  logic [PPN_W-1:0] table_ppn,
   input  logic [LVL_W-1:0] level,
   output logic [PA_W-1:0]  pte_addr
);

   logic [IDX_W-1:0] idx_arr [LEVELS];
   logic [IDX_W-1:0] idx_sel;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_idx
         assign idx_arr[g] = vpn[g*IDX_W +: IDX_W];
      end
   endgenerate

   always_comb begin
      idx_sel = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (level == LVL_W'(i)) idx_sel = idx_arr[i];
      end
   end

   generate
      if (USE_CONCAT) begin : g_cat
         if (IDX_W + SH != OFF_W) begin : g_bad_fit
            $error("ptw_addr: a table must fill exactly one page for concatenation");
         end
         assign pte_addr = {table_ppn, idx_sel, {SH{1'b0}}};
      end else begin : g_add
         assign pte_addr = {table_ppn, {OFF_W{1'b0}}} + (PA_W'(idx_sel) << SH);
      end
   endgenerate

endmodule

// File: rtl/ptw_pte_dec.sv
// Classifies a fetched entry and extracts its page number.
module ptw_pte_dec
   import ptw_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int PPN_W    = 44,
   parameter int PPN_LSB  = 10,
   parameter int V_BIT    = 0,
   parameter int PERM_LSB = 1,
   parameter int PERM_W   = 3
) (
   input  logic [PTE_W-1:0] pte,
   output pte_kind_e        kind,
   output logic [PPN_W-1:0] ppn
);

   if (PPN_LSB + PPN_W > PTE_W) begin : g_bad_ppn
      $error("ptw_pte_dec: page number field exceeds entry width");
   end
   if (PERM_LSB + PERM_W > PPN_LSB || V_BIT >= PERM_LSB) begin : g_bad_flags
      $error("ptw_pte_dec: flag fields overlap");
   end

   logic unused_bits;
   assign unused_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:PERM_LSB+PERM_W]};

   assign ppn = pte[PPN_LSB +: PPN_W];

   always_comb begin
      if (!pte[V_BIT])                      kind = PK_INVALID;
      else if (|pte[PERM_LSB +: PERM_W])   kind = PK_LEAF;
      else                                  kind = PK_POINTER;
   end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import ptw_pkg::*;
#(
   parameter int VA_W        = 39,
   parameter int PA_W        = 56,
   parameter int OFF_W       = 12,
   parameter int IDX_W       = 9,
   parameter int LEVELS      = 3,
   parameter int PTE_W       = 64,
   parameter int PPN_LSB     = 10,
   parameter bit USE_CONCAT  = 1'b1,
   localparam int PPN_W      = PA_W - OFF_W,
   localparam int LVL_W      = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              root_we,
   input  logic [PPN_W-1:0]  root_ppn,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_va,
   output logic              mem_req_valid,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_resp_valid,
   input  logic [PTE_W-1:0]  mem_resp_data,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [PA_W-1:0]   rsp_pa
);

   if (VA_W != OFF_W + LEVELS * IDX_W) begin : g_bad_va
      $error("pt_walker: virtual address width does not match offset plus indices");
   end
   if (LEVELS != 3) begin : g_bad_levels
      $error("pt_walker: state machine is built for three levels");
   end

   walk_state_e      st_q;
   logic [VA_W-1:0]  va_q;
   logic [PPN_W-1:0] root_q;
   logic [PPN_W-1:0] tbl_q;
   logic [PA_W-1:0]  pa_q;
   logic [LVL_W-1:0] level;
   pte_kind_e        kind;
   logic [PPN_W-1:0] ent_ppn;
   logic             fetching;

   assign fetching = (st_q == WS_L2) || (st_q == WS_L1) || (st_q == WS_L0);

   always_comb begin
      case (st_q)
         WS_L2:   level = LVL_W'(2);
         WS_L1:   level = LVL_W'(1);
         default: level = LVL_W'(0);
      endcase
   end

   ptw_addr #(
      .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
      .ENTRY_BYTES(PTE_W / 8), .USE_CONCAT(USE_CONCAT)
   ) u_addr (
      .vpn       (va_q[VA_W-1:OFF_W]),
      .table_ppn (tbl_q),
      .level     (level),
      .pte_addr  (mem_req_addr)
   );

   ptw_pte_dec #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB)
   ) u_dec (
      .pte  (mem_resp_data),
      .kind (kind),
      .ppn  (ent_ppn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_IDLE;
         va_q   <= '0;
         root_q <= '0;
         tbl_q  <= '0;
         pa_q   <= '0;
      end else begin
         if (root_we && st_q == WS_IDLE) root_q <= root_ppn;
         case (st_q)
            WS_IDLE: begin
               if (req_valid) begin
                  va_q  <= req_va;
                  tbl_q <= root_q;
                  st_q  <= WS_L2;
               end
            end
            WS_L2, WS_L1, WS_L0: begin
               if (mem_resp_valid) begin
                  case (kind)
                     PK_LEAF: begin
                        pa_q <= {ent_ppn, va_q[OFF_W-1:0]};
                        st_q <= WS_DONE;
                     end
                     PK_POINTER: begin
                        tbl_q <= ent_ppn;
                        if (st_q == WS_L2)      st_q <= WS_L1;
                        else if (st_q == WS_L1) st_q <= WS_L0;
                        else                    st_q <= WS_FAULT;
                     end
                     default: st_q <= WS_FAULT;
                  endcase
               end
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == WS_IDLE);
   assign mem_req_valid = fetching;
   assign rsp_valid     = (st_q == WS_DONE) || (st_q == WS_FAULT);
   assign rsp_fault     = (st_q == WS_FAULT);
   assign rsp_pa        = (st_q == WS_DONE) ? pa_q : '0;

   // R2: idle means no read and no response in flight
   p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !rsp_valid));

   // R2: an accepted request starts a read and closes the handshake
   p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_req_valid && !req_ready));

   // R5: an outstanding read stays put until its data returns
   p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_resp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R6: a fault never carries an address
   p_fault_zero_pa_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_pa == '0));

   // R9: single-cycle response, then idle
   p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R10: root register frozen while a walk is running
   p_root_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |=> $stable(root_q));

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        root_we = 1'b0;
   logic [43:0] root_ppn = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [38:0] req_va = '0;
   logic        mem_req_valid;
   logic [55:0] mem_req_addr;
   logic        mem_resp_valid;
   logic [63:0] mem_resp_data;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [55:0] rsp_pa;

   always #2.5 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_ppn(root_ppn),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
   );

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // sparse memory model with programmable latency
   logic [63:0] mem [logic [55:0]];
   logic        resp_v = 1'b0;
   logic [63:0] resp_d = '0;
   logic        m_busy = 1'b0;
   int          m_cnt = 0;
   logic [55:0] m_addr = '0;
   int          lat = 0;
   int          reads = 0;
   int          hold_err = 0;
   logic [55:0] log_first = '0;
   logic [55:0] log_last = '0;

   assign mem_resp_valid = resp_v;
   assign mem_resp_data  = resp_d;

   always @(posedge clk) begin
      if (!rst_n) begin
         resp_v <= 1'b0;
         m_busy <= 1'b0;
      end else if (resp_v) begin
         resp_v <= 1'b0;
      end else if (mem_req_valid) begin
         if (!m_busy) begin
            m_busy <= 1'b1;
            m_cnt  <= lat;
            m_addr <= mem_req_addr;
            if (reads == 0) log_first = mem_req_addr;
            log_last = mem_req_addr;
            reads = reads + 1;
         end else if (m_cnt == 0) begin
            if (mem_req_addr != m_addr) hold_err = hold_err + 1;
            resp_v <= 1'b1;
            resp_d <= mem.exists(m_addr) ? mem[m_addr] : 64'h0;
            m_busy <= 1'b0;
         end else begin
            if (mem_req_addr != m_addr) hold_err = hold_err + 1;
            m_cnt <= m_cnt - 1;
         end
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles = cycles + 1;
      if (cycles > 100000) begin
         total = total + 1;
         bad = bad + 1;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
         summary();
      end
   end

   task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total = total + 1;
      if (!cond) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ptr(input logic [43:0] p);
      return {10'h000, p, 6'h00, 4'h1};
   endfunction
   function automatic logic [63:0] leaf(input logic [43:0] p, input logic [3:0] fl);
      return {10'h3FF, p, 6'h2A, fl};
   endfunction

   task automatic load_root(input logic [43:0] p);
      @(negedge clk);
      root_we = 1'b1;
      root_ppn = p;
      @(negedge clk);
      root_we = 1'b0;
   endtask

   // one walk; poke asserts root_we with another value during the walk
   task automatic walk(input logic [38:0] va, input int lat_i, input bit poke,
                       output logic [55:0] pa, output logic f, output int nrd,
                       output bit ok, output int ready_err);
      @(negedge clk);
      lat = lat_i;
      reads = 0;
      req_va = va;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         root_we = 1'b1;
         root_ppn = 44'h999;
      end
      ok = 1'b0;
      ready_err = 0;
      for (int c = 0; c < 300; c++) begin
         if (rsp_valid) begin
            ok = 1'b1;
            break;
         end
         if (req_ready) ready_err = ready_err + 1;
         @(negedge clk);
         root_we = 1'b0;
      end
      root_we = 1'b0;
      pa = rsp_pa;
      f = rsp_fault;
      nrd = reads;
   endtask

   localparam int NV = 7;
   localparam logic [38:0] VEC_VA [NV] = '{
      39'h00_0000_1234, 39'h00_0000_5ABC, 39'h7F_C060_7FFF, 39'h00_0000_2000,
      39'h00_4000_0000, 39'h00_0000_3000, 39'h00_0040_0010 };
   localparam logic [55:0] VEC_PA [NV] = '{
      56'h0000_00AB_CDE2_34, 56'h0000_0012_345A_BC, 56'hFF_FFFF_FFFF_FFFF, 56'h0,
      56'h0, 56'h0, 56'h0000_0000_7770_10 };
   localparam bit VEC_F [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
   localparam int VEC_RD [NV] = '{3, 3, 3, 3, 1, 3, 2};
   localparam logic [55:0] VEC_AL [NV] = '{
      56'h10_2008, 56'h10_2028, 56'h20_1038, 56'h10_2010,
      56'h10_0008, 56'h10_2018, 56'h10_1010 };
   localparam string VEC_TAG [NV] = '{"R7", "R7", "R7", "R6", "R6", "R8", "R7"};

   initial begin
      logic [55:0] pa;
      logic        f;
      int          nrd;
      bit          ok;
      int          rerr;
      logic [55:0] exp_a0;

      mem[56'h10_0000] = ptr(44'h101);
      mem[56'h10_1000] = ptr(44'h102);
      mem[56'h10_2008] = leaf(44'hABCDE, 4'h3);
      mem[56'h10_2028] = leaf(44'h12345, 4'h9);
      mem[56'h10_0FF8] = ptr(44'h200);
      mem[56'h20_0018] = ptr(44'h201);
      mem[56'h20_1038] = leaf(44'hFFF_FFFF_FFFF, 4'h5);
      mem[56'h10_2018] = ptr(44'h300);
      mem[56'h10_1010] = leaf(44'h777, 4'hF);

      repeat (3) @(negedge clk);
      // R1: reset state while held in reset
      chk(req_ready === 1'b1, "R1 req_ready in reset", 64'(req_ready), 64'h1);
      chk(mem_req_valid === 1'b0, "R1 mem_req_valid in reset", 64'(mem_req_valid), 64'h0);
      chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1 && !mem_req_valid, "R1 idle after reset", 64'(mem_req_valid), 64'h0);

      // R1: root resets to 0, so the first walk reads from page 0
      walk(VEC_VA[0], 0, 1'b0, pa, f, nrd, ok, rerr);
      chk(log_first == 56'h0, "R1 root reset value", 64'(log_first), 64'h0);
      chk(ok && f == 1'b1 && nrd == 1, "R6 empty root faults", 64'(nrd), 64'h1);

      load_root(44'h100);

      for (int i = 0; i < NV; i++) begin
         walk(VEC_VA[i], i % 3, 1'b0, pa, f, nrd, ok, rerr);
         exp_a0 = {44'h100, 12'h000} + 56'(VEC_VA[i][38:30]) * 8;
         chk(ok, "R11 walk completes", 64'(ok), 64'h1);
         chk(pa == VEC_PA[i], {VEC_TAG[i], " rsp_pa"}, 64'(pa), 64'(VEC_PA[i]));
         chk(f == VEC_F[i], {VEC_TAG[i], " rsp_fault"}, 64'(f), 64'(VEC_F[i]));
         chk(nrd == VEC_RD[i], "R11 read count", 64'(nrd), 64'(VEC_RD[i]));
         chk(log_first == exp_a0, "R3 first read address", 64'(log_first), 64'(exp_a0));
         chk(log_last == VEC_AL[i], "R4 last read address", 64'(log_last), 64'(VEC_AL[i]));
         chk(rerr == 0, "R2 req_ready low while busy", 64'(rerr), 64'h0);
         @(negedge clk);
         chk(!rsp_valid && req_ready, "R9 pulse then ready", 64'(rsp_valid), 64'h0);
      end

      // R5: address held during multi-cycle latency
      chk(hold_err == 0, "R5 address hold", 64'(hold_err), 64'h0);

      // R10: root load during a walk is dropped
      walk(VEC_VA[0], 2, 1'b1, pa, f, nrd, ok, rerr);
      chk(pa == 56'hAB_CDE2_34 && !f, "R10 walk unaffected by busy load", 64'(pa), 64'hABCDE234);
      walk(VEC_VA[1], 0, 1'b0, pa, f, nrd, ok, rerr);
      chk(log_first == 56'h10_0000, "R10 root kept after busy load", 64'(log_first), 64'h100000);
      chk(pa == 56'h12_345A_BC && !f, "R10 next walk uses old root", 64'(pa), 64'h12345ABC);

      // R10: root load while idle takes effect
      load_root(44'h400);
      walk(VEC_VA[0], 1, 1'b0, pa, f, nrd, ok, rerr);
      chk(log_first == 56'h40_0000, "R10 idle load used", 64'(log_first), 64'h400000);
      chk(f == 1'b1 && pa == 56'h0 && nrd == 1, "R6 fault at top level", 64'(nrd), 64'h1);

      summary();
   end

endmodule